// File: doc/BRIEF.md
# Scheduled Per-Partition Scan Clock Gater

This block drives the shift clocks of a test wrapper around a core that has been cut into several partitions. Each partition may be a whole clock domain or only part of one, and each is shifted on its own schedule. The block takes three inputs:

- a fast reference test clock;
- a one-cycle start strobe;
- the functional clock of every partition.

It also takes a static schedule. For each partition the schedule gives a start cycle, a divider select and a shift length, counted in shift pulses. The capture phase has its own length.

Outside a test pattern, every partition output carries its functional clock. After the strobe, one counter starts from zero and counts reference cycles. Each partition receives a latch-gated copy of the reference clock. It gets exactly one pulse every 2^d reference cycles inside its own window, so partitions can shift one after another, overlap, or run at different rates. When the last window has closed, the block enters capture for a programmed number of cycles and hands all outputs back to the functional clocks. It then raises a done flag and goes back to idle.

Top module: `scan_clk_sched`

## Requirements
- R1: While reset is asserted, every `part_clk` bit equals its `func_clk` bit, and `part_se`, `capture` and `done` are all 0.
- R2: In idle, every `part_clk` bit follows its `func_clk` bit.
- R3: After `test_start` is sampled in idle, a cycle counter starts at 0. Partition i, with start S, effective select d and length L > 0, produces L high pulses on `part_clk[i]`, one in the high phase after each counter value S + k·2^d (k = 0..L-1). Its output stays low at every other time during the shift phase.
- R4: `part_se[i]` is 1 exactly while the shift-phase counter lies in [S, S + L·2^d).
- R5: A partition whose length is 0 gets no pulse and never asserts `part_se`.
- R6: A divider select above NDIV-1 behaves as NDIV-1, which is the slowest rate.
- R7: The shift phase ends when the counter reaches the largest S + L·2^d over the partitions with L > 0. The next cycles are capture (`capture` = 1) for max(cap_len, 1) cycles, and during them every `part_clk` follows `func_clk`.
- R8: When capture ends, `done` rises and stays at 1 in idle until the next accepted `test_start`. A `test_start` pulse during shift or capture has no effect.
- R9: If every length is 0, the shift phase lasts one cycle and capture follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference test clock (fastest shift rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_start | input | 1 | Starts a pattern when sampled in idle |
| func_clk | input | NPART | Functional clock of each partition |
| sched_start | input | NPART*SW | Start cycle of each partition |
| sched_div | input | NPART*DSW | Divider select of each partition (rate = clk_ref / 2^d) |
| sched_len | input | NPART*LW | Shift length of each partition in pulses |
| cap_len | input | CAPW | Capture window length in reference cycles |
| part_clk | output | NPART | Gated shift or functional clock of each partition |
| part_se | output | NPART | Scan enable of each partition |
| capture | output | 1 | High during the capture window |
| done | output | 1 | Pattern finished; held in idle |

## Verification
A counter that is off by one shows up at the ports in the first cycle of the affected partition's window. It either adds a pulse on `part_clk` in the high phase or drops one, and it shifts the edges of `part_se` by one reference cycle. A wrong window end or a wrong clamp of the select makes capture begin early or late, which is visible on `capture` within the same cycle. A clock mux that is stuck on one source shows at a single half-period sample in either phase. The bench therefore predicts every output at both the high and the low half of every reference cycle.

// File: rtl/scan_clk_sched.sv
`timescale 1ns/100ps
module scan_clk_sched #(
  parameter int NPART = 4,
  parameter int SW    = 12,
  parameter int LW    = 10,
  parameter int DSW   = 3,
  parameter int NDIV  = 4,
  parameter int CAPW  = 8
) (
  input  logic                  clk_ref,
  input  logic                  rst_n,
  input  logic                  test_start,
  input  logic [NPART-1:0]      func_clk,
  input  logic [NPART*SW-1:0]   sched_start,
  input  logic [NPART*DSW-1:0]  sched_div,
  input  logic [NPART*LW-1:0]   sched_len,
  input  logic [CAPW-1:0]       cap_len,
  output logic [NPART-1:0]      part_clk,
  output logic [NPART-1:0]      part_se,
  output logic                  capture,
  output logic                  done
);
  localparam int MAXD = NDIV - 1;
  localparam int TW   = ((SW > LW + MAXD) ? SW : LW + MAXD) + 1;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_CAP} st_t;

  st_t             st;
  logic [TW-1:0]   cnt;
  logic [TW-1:0]   shift_end;
  logic [TW-1:0]   win_end [NPART];
  logic [NPART-1:0] act, en_c, en_lat, has_len;

  for (genvar g = 0; g < NPART; g++) begin : g_part
    logic [DSW-1:0] dsel;
    logic [TW-1:0]  st_ext, len_ext, off, mask;

    assign dsel       = (sched_div[g*DSW +: DSW] > DSW'(MAXD)) ? DSW'(MAXD) : sched_div[g*DSW +: DSW];
    assign st_ext     = TW'(sched_start[g*SW +: SW]);
    assign len_ext    = TW'(sched_len[g*LW +: LW]);
    assign has_len[g] = (len_ext != '0);
    assign win_end[g] = st_ext + (len_ext << dsel);
    assign off        = cnt - st_ext;
    assign mask       = ~({TW{1'b1}} << dsel);
    assign act[g]     = (st == S_SHIFT) && has_len[g] && (cnt >= st_ext) && (cnt < win_end[g]);
    assign en_c[g]    = act[g] && ((off & mask) == '0);

    always_latch
      if (!clk_ref) en_lat[g] = en_c[g];

    assign part_clk[g] = (st == S_SHIFT) ? (clk_ref & en_lat[g]) : func_clk[g];
  end

  always_comb begin
    shift_end = '0;
    for (int i = 0; i < NPART; i++)
      if (has_len[i] && win_end[i] > shift_end) shift_end = win_end[i];
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (test_start) begin
            st   <= S_SHIFT;
            cnt  <= '0;
            done <= 1'b0;
          end
        S_SHIFT:
          if (cnt >= shift_end) begin
            st  <= S_CAP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_CAP:
          if (cnt + TW'(1) >= TW'(cap_len)) begin
            st   <= S_IDLE;
            cnt  <= '0;
            done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign part_se = act;
  assign capture = (st == S_CAP);
endmodule

module scan_clk_sched_chk #(
  parameter int NPART = 4,
  parameter int LW    = 10
) (
  input logic                clk_ref,
  input logic                rst_n,
  input logic                capture,
  input logic                done,
  input logic [NPART-1:0]    part_se,
  input logic [NPART*LW-1:0] sched_len
);
  p_se_quiet_in_capture_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    capture |-> (part_se == '0));
  p_done_excl_capture_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done |-> !capture);
  p_done_from_capture_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(done) |-> $past(capture));
  p_capture_ends_done_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(capture) |-> done);
  p_se_not_when_done_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (part_se != '0) |-> !done);

  for (genvar g = 0; g < NPART; g++) begin : g_chk
    p_zero_len_quiet_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (sched_len[g*LW +: LW] == '0) |-> !part_se[g]);
  end
endmodule

bind scan_clk_sched scan_clk_sched_chk #(.NPART(NPART), .LW(LW)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .capture(capture), .done(done),
  .part_se(part_se), .sched_len(sched_len)
);

// File: tb/sim_scan_clk_sched.sv
`timescale 1ns/100ps
module sim_scan_clk_sched;
  localparam int NP = 4, SW = 12, LW = 10, DSW = 3, NDIV = 4, CAPW = 8;

  logic clk, rst_n, test_start;
  logic [NP-1:0] fclk;
  logic [NP*SW-1:0] v_start;
  logic [NP*DSW-1:0] v_div;
  logic [NP*LW-1:0] v_len;
  logic [CAPW-1:0] v_cap;
  logic [NP-1:0] part_clk, part_se;
  logic capture, done;

  scan_clk_sched #(.NPART(NP), .SW(SW), .LW(LW), .DSW(DSW), .NDIV(NDIV), .CAPW(CAPW)) u0 (
    .clk_ref(clk), .rst_n(rst_n), .test_start(test_start), .func_clk(fclk),
    .sched_start(v_start), .sched_div(v_div), .sched_len(v_len), .cap_len(v_cap),
    .part_clk(part_clk), .part_se(part_se), .capture(capture), .done(done)
  );

  int s_start[NP], s_div[NP], s_len[NP], s_cap;
  int n_cmp = 0, n_bad = 0;
  string scen_tag = "R3";

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin fclk = '0; #0.5; end
  initial begin #0.5; forever #7  fclk[0] = ~fclk[0]; end
  initial begin #0.5; forever #9  fclk[1] = ~fclk[1]; end
  initial begin #0.5; forever #11 fclk[2] = ~fclk[2]; end
  initial begin #0.5; forever #13 fclk[3] = ~fclk[3]; end

  function automatic int dclamp(int i);
    return (s_div[i] > NDIV - 1) ? NDIV - 1 : s_div[i];
  endfunction
  function automatic int wend(int i);
    return s_start[i] + s_len[i] * (1 << dclamp(i));
  endfunction
  function automatic bit act_at(int c, int i);
    return s_len[i] > 0 && c >= s_start[i] && c < wend(i);
  endfunction
  function automatic bit en_at(int c, int i);
    return act_at(c, i) && (((c - s_start[i]) % (1 << dclamp(i))) == 0);
  endfunction
  function automatic int send();
    int m = 0;
    for (int i = 0; i < NP; i++) if (s_len[i] > 0 && wend(i) > m) m = wend(i);
    return m;
  endfunction

  task automatic load();
    for (int i = 0; i < NP; i++) begin
      v_start[i*SW +: SW] = SW'(s_start[i]);
      v_div[i*DSW +: DSW] = DSW'(s_div[i]);
      v_len[i*LW +: LW]   = LW'(s_len[i]);
    end
    v_cap = CAPW'(s_cap);
  endtask

  task automatic cmp(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, advanced at each rising edge
  int m_mode = 0, m_cnt = 0;
  bit m_done = 0;
  bit m_pulse[NP];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_done = 0;
      for (int i = 0; i < NP; i++) m_pulse[i] = 0;
    end else begin
      for (int i = 0; i < NP; i++) m_pulse[i] = (m_mode == 1) && en_at(m_cnt, i);
      case (m_mode)
        0: if (test_start) begin m_mode = 1; m_cnt = 0; m_done = 0; end
        1: if (m_cnt >= send()) begin m_mode = 2; m_cnt = 0; end else m_cnt++;
        default: if (m_cnt + 1 >= ((s_cap < 1) ? 1 : s_cap)) begin
                   m_mode = 0; m_cnt = 0; m_done = 1;
                 end else m_cnt++;
      endcase
    end
  end

  function automatic string clk_tag();
    if (!rst_n) return "R1";
    if (m_mode == 0) return "R2";
    if (m_mode == 2) return "R7";
    return scen_tag;
  endfunction

  always @(posedge clk) begin
    #2;
    for (int i = 0; i < NP; i++) begin
      cmp(clk_tag(), $sformatf("part_clk[%0d] high", i), int'(part_clk[i]),
          (m_mode == 1) ? int'(m_pulse[i]) : int'(fclk[i]));
      cmp(!rst_n ? "R1" : (s_len[i] == 0 ? "R5" : "R4"), $sformatf("part_se[%0d]", i),
          int'(part_se[i]), (m_mode == 1 && act_at(m_cnt, i)) ? 1 : 0);
    end
    cmp(!rst_n ? "R1" : (scen_tag == "R9" ? "R9" : "R7"), "capture", int'(capture), (m_mode == 2) ? 1 : 0);
    cmp(!rst_n ? "R1" : "R8", "done", int'(done), int'(m_done));
    #4;
    for (int i = 0; i < NP; i++)
      cmp(clk_tag(), $sformatf("part_clk[%0d] low", i), int'(part_clk[i]),
          (m_mode == 1) ? 0 : int'(fclk[i]));
  end

  task automatic pulse_start();
    @(negedge clk) test_start = 1'b1;
    @(negedge clk) test_start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!(done && !capture) && k < 2000) begin @(negedge clk); k++; end
    if (k >= 2000) begin n_bad++; $display("FAIL R8 done never seen actual=0 expected=1"); end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < NP; i++) begin s_start[i] = 0; s_div[i] = 0; s_len[i] = 0; end
    s_cap = 1; load();
    test_start = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (10) @(negedge clk);               // R2 idle passthrough

    // R3: staggered, mixed rates, one empty partition (R5)
    scen_tag = "R3";
    s_start = '{0, 5, 2, 7}; s_div = '{0, 1, 2, 0}; s_len = '{5, 3, 4, 0}; s_cap = 4;
    load();
    pulse_start();
    repeat (6) @(negedge clk);
    test_start = 1'b1;                        // R8: ignored while shifting
    @(negedge clk) test_start = 1'b0;
    wait_done();
    repeat (8) @(negedge clk);                // R8: done held in idle

    // R6: selects beyond range clamp to slowest; overlapping windows
    scen_tag = "R6";
    s_start = '{1, 0, 3, 10}; s_div = '{6, 7, 0, 1}; s_len = '{3, 2, 6, 1}; s_cap = 0;
    load();
    pulse_start();
    wait_done();
    repeat (5) @(negedge clk);

    // R3: back-to-back hand-off between partitions, same rate
    scen_tag = "R3";
    s_start = '{0, 8, 16, 24}; s_div = '{1, 1, 1, 1}; s_len = '{4, 4, 4, 4}; s_cap = 3;
    load();
    pulse_start();
    wait_done();
    repeat (4) @(negedge clk);

    // R9: nothing to shift
    scen_tag = "R9";
    s_len = '{0, 0, 0, 0}; s_cap = 2;
    load();
    pulse_start();
    wait_done();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule